// File: doc/BRIEF.md
# Tick-Paced Program Sequencer

This block is the control unit of a small programmable controller. It keeps a program counter that holds line numbers starting at 1, a register file of general registers, and a set of output signal registers that are driven out continuously. An external program store returns the instruction fields of the line that `pc_o` points at. The sequencer executes at most one instruction per tick strobe. Jump-and-link, register jump, wait, no-op, halt and output writes complete inside the sequencer. Arithmetic and conditional branches are handed to outside units over a request/acknowledge handshake.

A wait instruction takes its count from an immediate or a register and stalls the program for that many whole ticks. A count of zero or less does nothing. Line 0 does not exist. Any jump or fall-through that lands on 0, or past the last program line given by `last_line_i`, restarts the program at line 1. There is no call stack, so nested calls need separate link registers. Halt freezes the block until reset.

Top module: `tick_seq`

## Requirements
- R1: Reset sets `pc_o` to 1, clears `halted_o`, and clears every general register and every output register.
- R2: Register 0 always reads as 0, and any write to it (link or calculation result) is discarded.
- R3: Opcode 2 (jump-and-link) writes the current line plus 1 into register `ins_rd_i` and moves to line `ins_tgt_i`. A target of 0 or above `last_line_i` moves to line 1.
- R4: Opcode 3 (register jump) moves to the value of register `ins_rs_i`. A value of 0, or a value above `last_line_i` read as unsigned, moves to line 1, so `pc_o` is never 0.
- R5: Opcodes 0 (no-op) and 5 (output write) move to the next line, and stepping past `last_line_i` wraps to line 1.
- R6: Opcode 4 (wait) reads a count N from `ins_imm_i` when `ins_imm_sel_i` is 1, and from register `ins_rs_i` when it is 0. With N > 0 (signed), the next line is reached exactly N ticks after the wait's own tick. With N <= 0 the next line is reached on the wait's own tick.
- R7: Opcode 5 writes register `ins_rs_i` into output slot `ins_rd_i[1:0]`, which is bits [32*k+31:32*k] of `sig_out_o` for slot k. The upper bits of `ins_rd_i` are ignored, and every other slot keeps its value.
- R8: Opcode 1 (halt) raises `halted_o`. After that, `pc_o` and `sig_out_o` stay frozen until reset.
- R9: Nothing executes in a cycle without `tick_i`. `pc_o` changes only on a tick or when a handshake completes.
- R10: Opcode 6 (calculation) raises `calc_req_o`, with `opnd_a_o` = register `ins_rs_i` and `opnd_b_o` = `ins_imm_i` if `ins_imm_sel_i` is set, otherwise register `ins_rt_i`. The request and operands hold until `calc_ack_i`. `calc_res_i` is then written to `ins_rd_i` and the program moves to the next line. Ticks that arrive during the handshake are dropped.
- R11: Opcode 7 (branch) raises `test_req_o` with the same operands. On `test_ack_i` the program moves to line `ins_tgt_i` (with the R3 wrap rule) if `test_take_i` is set, otherwise to the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Tick strobe, one instruction slot per pulse |
| last_line_i | input | LINE_W | Highest valid program line |
| pc_o | output | LINE_W | Current line number, addresses the program store |
| ins_op_i | input | 3 | Opcode of the current line |
| ins_rd_i | input | 5 | Destination register / output slot field |
| ins_rs_i | input | 5 | First source register |
| ins_rt_i | input | 5 | Second source register |
| ins_imm_sel_i | input | 1 | Use immediate instead of register |
| ins_imm_i | input | DATA_W | Immediate value |
| ins_tgt_i | input | LINE_W | Jump/branch target line |
| opnd_a_o | output | DATA_W | First operand to external units |
| opnd_b_o | output | DATA_W | Second operand to external units |
| calc_req_o | output | 1 | Calculation request |
| calc_ack_i | input | 1 | Calculation acknowledge |
| calc_res_i | input | DATA_W | Calculation result |
| test_req_o | output | 1 | Branch decision request |
| test_ack_i | input | 1 | Branch decision acknowledge |
| test_take_i | input | 1 | Branch taken |
| sig_out_o | output | NOUT*DATA_W | Output signal registers, slot k in bits [32k+31:32k] |
| halted_o | output | 1 | Program halted |

## Verification
On every cycle the assertions check four things. The line number is never 0. A halted block keeps its line and outputs frozen. Without a tick and outside a handshake the line does not move. A pending request keeps its operands steady until acknowledged. Only the bench scenarios can show the values that are computed: the stored link value, the exact number of ticks a wait lasts for positive, zero and negative counts, the wrap of register jumps across a range of values, which output slot a write lands in, and the clearing of registers by reset.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_HALT = 3'd1,
    OP_JAL  = 3'd2,
    OP_JR   = 3'd3,
    OP_WAIT = 3'd4,
    OP_PUT  = 3'd5,
    OP_CALC = 3'd6,
    OP_TEST = 3'd7
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STALL = 2'd1,
    ST_BUSY  = 2'd2,
    ST_HALT  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rd_a_idx,
  input  logic [REG_AW-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [DATA_W-1:0] wd
);

  logic [DATA_W-1:0] mem [NREG];

  // entry 0 is held at zero; only entries 1..NREG-1 accept writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (we && (wa == REG_AW'(i))) mem[i] <= wd;
      end
    end
  end

  assign rd_a = (rd_a_idx == '0) ? '0 : mem[rd_a_idx];
  assign rd_b = (rd_b_idx == '0) ? '0 : mem[rd_b_idx];

endmodule

// File: rtl/seq_outregs.sv
module seq_outregs #(
  parameter int DATA_W = 32,
  parameter int NOUT   = 4,
  localparam int OUT_AW = $clog2(NOUT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [OUT_AW-1:0]      sel,
  input  logic [DATA_W-1:0]      wd,
  output logic [NOUT*DATA_W-1:0] out_flat
);

  for (genvar g = 0; g < NOUT; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          slot_q <= '0;
      else if (we && sel == OUT_AW'(g))    slot_q <= wd;
    end
    assign out_flat[g*DATA_W +: DATA_W] = slot_q;
  end

endmodule

// File: rtl/seq_stall.sv
module seq_stall #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (tick && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // the last remaining tick of the stall is being consumed
  assign done = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/tick_seq.sv
module tick_seq
  import seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int NOUT   = 4,
  parameter int LINE_W = 10,
  localparam int REG_AW = $clog2(NREG),
  localparam int OUT_AW = $clog2(NOUT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [LINE_W-1:0]      last_line_i,
  output logic [LINE_W-1:0]      pc_o,
  input  logic [2:0]             ins_op_i,
  input  logic [REG_AW-1:0]      ins_rd_i,
  input  logic [REG_AW-1:0]      ins_rs_i,
  input  logic [REG_AW-1:0]      ins_rt_i,
  input  logic                   ins_imm_sel_i,
  input  logic [DATA_W-1:0]      ins_imm_i,
  input  logic [LINE_W-1:0]      ins_tgt_i,
  output logic [DATA_W-1:0]      opnd_a_o,
  output logic [DATA_W-1:0]      opnd_b_o,
  output logic                   calc_req_o,
  input  logic                   calc_ack_i,
  input  logic [DATA_W-1:0]      calc_res_i,
  output logic                   test_req_o,
  input  logic                   test_ack_i,
  input  logic                   test_take_i,
  output logic [NOUT*DATA_W-1:0] sig_out_o,
  output logic                   halted_o
);

  // ---------------- arithmetic helpers ----------------
  // a destination of 0 or beyond the last line restarts at line 1
  function automatic logic [LINE_W-1:0] fn_line_fix(input logic [DATA_W-1:0] want,
                                                    input logic [LINE_W-1:0] last);
    if (want == '0 || want > DATA_W'(last)) return LINE_W'(1);
    return want[LINE_W-1:0];
  endfunction

  // non-positive wait counts collapse to zero
  function automatic logic [DATA_W-1:0] fn_wait_len(input logic [DATA_W-1:0] n);
    if (n[DATA_W-1] || n == '0) return '0;
    return n;
  endfunction

  // ---------------- state ----------------
  seq_st_e           st_q, st_d;
  logic [LINE_W-1:0] pc_q, pc_d;
  seq_op_e           op;

  logic [DATA_W-1:0] rs_val, rt_val;
  logic [DATA_W-1:0] link_val;
  logic [DATA_W-1:0] wait_src, wait_len;
  logic [LINE_W-1:0] seq_next, jal_dest, jr_dest;

  // named internal events (used by the bound checker as well)
  logic exec_fire, calc_done, test_done, stall_load, stall_done;
  logic reg_we;
  logic [REG_AW-1:0] reg_wa;
  logic [DATA_W-1:0] reg_wd;
  logic put_we;

  assign op        = seq_op_e'(ins_op_i);
  assign exec_fire = (st_q == ST_RUN) && tick_i;
  assign calc_done = (st_q == ST_BUSY) && (op == OP_CALC) && calc_ack_i;
  assign test_done = (st_q == ST_BUSY) && (op == OP_TEST) && test_ack_i;

  assign link_val  = DATA_W'(pc_q) + DATA_W'(1);
  assign seq_next  = fn_line_fix(link_val, last_line_i);
  assign jal_dest  = fn_line_fix(DATA_W'(ins_tgt_i), last_line_i);
  assign jr_dest   = fn_line_fix(rs_val, last_line_i);

  assign wait_src   = ins_imm_sel_i ? ins_imm_i : rs_val;
  assign wait_len   = fn_wait_len(wait_src);
  assign stall_load = exec_fire && (op == OP_WAIT) && (wait_len != '0);

  assign reg_we = (exec_fire && op == OP_JAL) || calc_done;
  assign reg_wa = ins_rd_i;
  assign reg_wd = (op == OP_JAL) ? link_val : calc_res_i;
  assign put_we = exec_fire && (op == OP_PUT);

  // ---------------- submodules ----------------
  seq_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ins_rs_i),
    .rd_b_idx (ins_rt_i),
    .rd_a     (rs_val),
    .rd_b     (rt_val),
    .we       (reg_we),
    .wa       (reg_wa),
    .wd       (reg_wd)
  );

  seq_outregs #(.DATA_W(DATA_W), .NOUT(NOUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (put_we),
    .sel      (ins_rd_i[OUT_AW-1:0]),
    .wd       (rs_val),
    .out_flat (sig_out_o)
  );

  seq_stall #(.CNT_W(DATA_W)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stall_load),
    .load_val (wait_len),
    .tick     (tick_i),
    .done     (stall_done)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    unique case (st_q)
      ST_RUN: begin
        if (tick_i) begin
          unique case (op)
            OP_NOP, OP_PUT:   pc_d = seq_next;
            OP_HALT:          st_d = ST_HALT;
            OP_JAL:           pc_d = jal_dest;
            OP_JR:            pc_d = jr_dest;
            OP_WAIT: begin
              if (wait_len == '0) pc_d = seq_next;
              else                st_d = ST_STALL;
            end
            OP_CALC, OP_TEST: st_d = ST_BUSY;
            default:          ;
          endcase
        end
      end
      ST_STALL: begin
        if (stall_done) begin
          pc_d = seq_next;
          st_d = ST_RUN;
        end
      end
      ST_BUSY: begin
        if (calc_done) begin
          pc_d = seq_next;
          st_d = ST_RUN;
        end else if (test_done) begin
          pc_d = test_take_i ? jal_dest : seq_next;
          st_d = ST_RUN;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
      pc_q <= LINE_W'(1);
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign pc_o       = pc_q;
  assign halted_o   = (st_q == ST_HALT);
  assign opnd_a_o   = rs_val;
  assign opnd_b_o   = ins_imm_sel_i ? ins_imm_i : rt_val;
  assign calc_req_o = (st_q == ST_BUSY) && (op == OP_CALC);
  assign test_req_o = (st_q == ST_BUSY) && (op == OP_TEST);

endmodule

// File: rtl/tick_seq_chk.sv
module tick_seq_chk #(
  parameter int DATA_W = 32,
  parameter int NOUT   = 4,
  parameter int LINE_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_i,
  input logic [LINE_W-1:0]      pc_o,
  input logic                   halted_o,
  input logic [NOUT*DATA_W-1:0] sig_out_o,
  input logic                   calc_req_o,
  input logic                   calc_ack_i,
  input logic                   test_req_o,
  input logic                   test_ack_i,
  input logic [DATA_W-1:0]      opnd_a_o,
  input logic [DATA_W-1:0]      opnd_b_o
);

  AST_PC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o != '0);  // R4

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o && $stable(pc_o) && $stable(sig_out_o));  // R8

  AST_IDLE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !calc_req_o && !test_req_o) |=> $stable(pc_o));  // R9

  AST_CALC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_req_o && !calc_ack_i) |=> calc_req_o && $stable(opnd_a_o) && $stable(opnd_b_o));  // R10

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && !test_ack_i) |=> test_req_o && $stable(opnd_a_o) && $stable(opnd_b_o));  // R11

endmodule

bind tick_seq tick_seq_chk #(.DATA_W(DATA_W), .NOUT(NOUT), .LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .pc_o       (pc_o),
  .halted_o   (halted_o),
  .sig_out_o  (sig_out_o),
  .calc_req_o (calc_req_o),
  .calc_ack_i (calc_ack_i),
  .test_req_o (test_req_o),
  .test_ack_i (test_ack_i),
  .opnd_a_o   (opnd_a_o),
  .opnd_b_o   (opnd_b_o)
);

// File: tb/tick_seq_bench.sv
module tick_seq_bench;

  localparam int DW = 32;
  localparam int LW = 10;
  localparam int NL = 16;

  localparam int C_NOP = 0, C_HALT = 1, C_JAL = 2, C_JR = 3,
                 C_WAIT = 4, C_PUT = 5, C_CALC = 6, C_TEST = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic [LW-1:0] last_line_i = LW'(6);
  logic [LW-1:0] pc_o;
  logic [2:0]    ins_op_i;
  logic [4:0]    ins_rd_i, ins_rs_i, ins_rt_i;
  logic          ins_imm_sel_i;
  logic [DW-1:0] ins_imm_i;
  logic [LW-1:0] ins_tgt_i;
  logic [DW-1:0] opnd_a_o, opnd_b_o;
  logic          calc_req_o, test_req_o;
  logic          calc_ack_i = 1'b0;
  logic [DW-1:0] calc_res_i = '0;
  logic          test_ack_i = 1'b0;
  logic          test_take_i = 1'b0;
  logic [4*DW-1:0] sig_out_o;
  logic          halted_o;

  always #4 clk = ~clk;  // 125 MHz

  // program store
  logic [2:0]    p_op  [NL];
  logic [4:0]    p_rd  [NL];
  logic [4:0]    p_rs  [NL];
  logic [4:0]    p_rt  [NL];
  logic          p_sel [NL];
  logic [DW-1:0] p_imm [NL];
  logic [LW-1:0] p_tgt [NL];

  logic [3:0] pidx;
  assign pidx          = pc_o[3:0];
  assign ins_op_i      = p_op[pidx];
  assign ins_rd_i      = p_rd[pidx];
  assign ins_rs_i      = p_rs[pidx];
  assign ins_rt_i      = p_rt[pidx];
  assign ins_imm_sel_i = p_sel[pidx];
  assign ins_imm_i     = p_imm[pidx];
  assign ins_tgt_i     = p_tgt[pidx];

  tick_seq u_tick_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .last_line_i(last_line_i), .pc_o(pc_o),
    .ins_op_i(ins_op_i), .ins_rd_i(ins_rd_i), .ins_rs_i(ins_rs_i), .ins_rt_i(ins_rt_i),
    .ins_imm_sel_i(ins_imm_sel_i), .ins_imm_i(ins_imm_i), .ins_tgt_i(ins_tgt_i),
    .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o),
    .calc_req_o(calc_req_o), .calc_ack_i(calc_ack_i), .calc_res_i(calc_res_i),
    .test_req_o(test_req_o), .test_ack_i(test_ack_i), .test_take_i(test_take_i),
    .sig_out_o(sig_out_o), .halted_o(halted_o)
  );

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int c_wait = 0;

  // external units: adder and signed less-than, with programmable latency
  always @(negedge clk) begin
    if (calc_req_o) begin
      if (c_wait == 0) begin calc_ack_i = 1'b1; calc_res_i = opnd_a_o + opnd_b_o; end
      else c_wait = c_wait - 1;
    end else if (test_req_o) begin
      if (c_wait == 0) begin
        test_ack_i = 1'b1; test_take_i = ($signed(opnd_a_o) < $signed(opnd_b_o));
      end else c_wait = c_wait - 1;
    end else begin
      calc_ack_i = 1'b0; test_ack_i = 1'b0; c_wait = lat;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NL; i++) begin
      p_op[i] = 3'(C_NOP); p_rd[i] = '0; p_rs[i] = '0; p_rt[i] = '0;
      p_sel[i] = 1'b0; p_imm[i] = '0; p_tgt[i] = '0;
    end
  endtask

  task automatic set_line(input int ln, input int op, input int rd, input int rs, input int rt,
                          input bit sel, input int imm, input int tgt);
    p_op[ln] = 3'(op); p_rd[ln] = 5'(rd); p_rs[ln] = 5'(rs); p_rt[ln] = 5'(rt);
    p_sel[ln] = sel; p_imm[ln] = DW'(imm); p_tgt[ln] = LW'(tgt);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    while (calc_req_o || test_req_o) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] slot(input int k);
    return sig_out_o[k*DW +: DW];
  endfunction

  function automatic int fix_line(input longint v, input int last);
    if (v <= 0 || v > last) return 1;
    return int'(v);
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_prog();
    last_line_i = LW'(6);

    // R1: reset state, then registers cleared by reset
    set_line(1, C_CALC, 5, 0, 0, 1'b1, 77, 0);
    set_line(2, C_PUT, 0, 5, 0, 1'b0, 0, 0);
    set_line(3, C_HALT, 0, 0, 0, 1'b0, 0, 0);
    do_reset();
    check("R1 pc after reset", pc_o, 1);
    check("R1 halted after reset", halted_o, 0);
    check("R1 outputs after reset", sig_out_o, 0);
    // R9: no tick, no progress
    repeat (5) @(negedge clk);
    check("R9 pc without tick", pc_o, 1);
    check("R9 outputs without tick", sig_out_o, 0);
    do_tick(); do_tick();
    check("R10 calc result through slot 0", slot(0), 77);
    do_reset();
    check("R1 outputs cleared by reset", sig_out_o, 0);
    set_line(1, C_NOP, 0, 0, 0, 1'b0, 0, 0);
    do_tick(); do_tick();
    check("R1 register cleared by reset", slot(0), 0);

    // R3 / R2: link into every register
    for (int r = 0; r < 32; r++) begin
      clear_prog();
      set_line(1, C_JAL, r, 0, 0, 1'b0, 0, 3);
      set_line(3, C_PUT, 1, r, 0, 1'b0, 0, 0);
      set_line(4, C_HALT, 0, 0, 0, 1'b0, 0, 0);
      do_reset();
      do_tick();
      check("R3 jal target", pc_o, 3);
      do_tick();
      check((r == 0) ? "R2 link to x0 discarded" : "R3 link value", slot(1), (r == 0) ? 0 : 2);
    end

    // R3: out-of-range jump targets restart
    for (int t = 0; t < 4; t++) begin
      int tg;
      tg = (t == 0) ? 0 : 5 + t;
      clear_prog();
      set_line(2, C_JAL, 0, 0, 0, 1'b0, 0, tg);
      do_reset();
      do_tick(); do_tick();
      check("R3 jal wrap", pc_o, fix_line(tg, 6));
    end

    // R4: register jump sweep
    for (int v = -2; v <= 9; v++) begin
      clear_prog();
      set_line(1, C_CALC, 9, 0, 0, 1'b1, v, 0);
      set_line(2, C_JR, 0, 9, 0, 1'b0, 0, 0);
      do_reset();
      do_tick(); do_tick();
      check("R4 jr destination", pc_o, fix_line(longint'(unsigned'(v)), 6));
    end

    // R5: sequential wrap past the last line
    clear_prog();
    last_line_i = LW'(4);
    do_reset();
    for (int k = 0; k < 6; k++) begin
      do_tick();
      check("R5 step", pc_o, (k + 1) % 4 + 1);
    end
    last_line_i = LW'(6);

    // R6: wait length sweep, immediate and register sourced
    for (int s = 0; s < 2; s++) begin
      for (int n = -2; n <= 5; n++) begin
        int k;
        clear_prog();
        set_line(1, C_CALC, 8, 0, 0, 1'b1, 9, 0);
        set_line(2, C_CALC, 7, 0, 0, 1'b1, n, 0);
        set_line(3, C_WAIT, 0, (s == 0) ? 0 : 7, 0, s == 0, (s == 0) ? n : 1000, 0);
        set_line(4, C_PUT, 0, 8, 0, 1'b0, 0, 0);
        set_line(5, C_HALT, 0, 0, 0, 1'b0, 0, 0);
        do_reset();
        do_tick(); do_tick(); do_tick();
        k = 0;
        while (pc_o == LW'(3) && k < 20) begin
          repeat (3) @(negedge clk);
          check("R9 stall waits for tick", pc_o, 3);
          do_tick(); k++;
        end
        check("R6 wait ticks", k, (n > 0) ? n : 0);
        do_tick();
        check("R6 resumes after wait", slot(0), 9);
      end
    end

    // R7: output slot sweep including ignored upper field bits
    for (int f = 0; f < 8; f++) begin
      clear_prog();
      set_line(1, C_CALC, 1, 0, 0, 1'b1, 11 + f, 0);
      set_line(2, C_PUT, f, 1, 0, 1'b0, 0, 0);
      set_line(3, C_HALT, 0, 0, 0, 1'b0, 0, 0);
      do_reset();
      do_tick(); do_tick();
      for (int k = 0; k < 4; k++)
        check("R7 slot contents", slot(k), (k == f % 4) ? 11 + f : 0);
    end

    // R10 / R2: held request, dropped tick, x0 write discarded
    clear_prog();
    lat = 4;
    set_line(1, C_CALC, 3, 0, 0, 1'b1, 21, 0);
    set_line(2, C_CALC, 4, 3, 3, 1'b0, 0, 0);
    set_line(3, C_CALC, 0, 0, 0, 1'b1, 5, 0);
    set_line(4, C_PUT, 2, 4, 0, 1'b0, 0, 0);
    set_line(5, C_PUT, 3, 0, 0, 1'b0, 0, 0);
    set_line(6, C_HALT, 0, 0, 0, 1'b0, 0, 0);
    do_reset();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    check("R10 request raised", calc_req_o, 1);
    check("R10 operand a", opnd_a_o, 0);
    check("R10 operand b", opnd_b_o, 21);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    while (calc_req_o) @(negedge clk);
    check("R10 tick during handshake dropped", pc_o, 2);
    do_tick(); do_tick(); do_tick(); do_tick();
    check("R10 register operands", slot(2), 42);
    check("R2 x0 reads zero after write", slot(3), 0);
    lat = 0;

    // R11: branch sweep, signed a < b
    for (int a = -2; a <= 2; a++) begin
      for (int b = -2; b <= 2; b++) begin
        clear_prog();
        set_line(1, C_CALC, 2, 0, 0, 1'b1, a, 0);
        set_line(2, C_TEST, 0, 2, 0, 1'b1, b, 5);
        do_reset();
        do_tick(); do_tick();
        check("R11 branch destination", pc_o, (a < b) ? 5 : 3);
      end
    end

    // R8: halt freezes state
    clear_prog();
    set_line(1, C_CALC, 1, 0, 0, 1'b1, 42, 0);
    set_line(2, C_PUT, 3, 1, 0, 1'b0, 0, 0);
    set_line(3, C_HALT, 0, 0, 0, 1'b0, 0, 0);
    set_line(4, C_PUT, 3, 0, 0, 1'b0, 0, 0);
    do_reset();
    repeat (6) do_tick();
    check("R8 halted flag", halted_o, 1);
    check("R8 pc frozen", pc_o, 3);
    check("R8 outputs frozen", slot(3), 42);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule